// File: doc/BRIEF.md
# One-Place Handshake Relay Controller

This block is a clocked one-place buffer that sits between a producing channel and a consuming channel, both running a four-phase request/acknowledge protocol. Toward the producer it is passive: it watches `prod_req` and answers on `prod_ack`. Toward the consumer it is active: it raises `cons_req` and waits for `cons_ack`. Each item is taken in, offered to the consumer, and both channels are walked back to zero before the same side can move again.

An item is taken only when the slot is empty and the consumer channel has fully returned to zero. This lets the block promise that the consumer request goes up on the clock after the producer acknowledge goes up, well inside a fixed response window. An optional data register captures `prod_data` on the accepting edge and presents it on `cons_data` for as long as `cons_req` is high. All inputs are assumed to be synchronous to `clk`.

Top module: `hs_relay_ctrl`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `prod_ack`, `cons_req` and `cons_data` are all zero and the slot is empty.
- R2: `prod_ack` rises only on an edge at which `prod_req` was sampled high.
- R3: Once high, `prod_ack` stays high on every edge at which `prod_req` is still sampled high.
- R4: Once high, `cons_req` stays high on every edge at which `cons_ack` is still sampled low.
- R5: Once low, `cons_req` stays low on every edge at which `cons_ack` is still sampled high.
- R6: Both channels return to zero: `prod_ack` falls on the first edge at which it is high and `prod_req` is sampled low, and `cons_req` falls on the first edge at which both it and `cons_ack` are high.
- R7: `cons_req` rises exactly one clock after `prod_ack` rises, and in any case no more than `RESP_LIMIT` (default 5) clocks after the item was taken.
- R8: `cons_req` is high only while an item is held; the consumer is never offered an item that has not been accepted.
- R9: While an accepted item has not been delivered (no edge yet with `cons_req` and `cons_ack` both high), a producer request is not acknowledged.
- R10: A producer request is not acknowledged on an edge at which `cons_ack` is sampled high.
- R11: With `HAS_DATA` set, `cons_data` equals the `prod_data` value sampled on the edge at which `prod_ack` rose, for every cycle `cons_req` is high, and is zero while `cons_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prod_req | input | 1 | Producer request (four-phase) |
| prod_data | input | DATA_W | Producer data, sampled when the item is taken |
| prod_ack | output | 1 | Acknowledge to the producer |
| cons_req | output | 1 | Request to the consumer |
| cons_ack | input | 1 | Consumer acknowledge (four-phase) |
| cons_data | output | DATA_W | Held item, valid while `cons_req` is high |

## Verification
The embedded assertions watch the per-cycle handshake rules on every clock: that each acknowledge or request only moves when its partner allows it, that requests drop after a completed exchange, that no offer exists without a held item, that the wait from acceptance to offer stays under the response limit, and that offered data stays stable. What only the bench scenarios can show is the end-to-end ordering and content of items: that every value sent by the producer reaches the consumer once and in order, that the offer comes exactly one clock after acceptance under every combination of producer and consumer delays in the sweep, and that a slow consumer really stalls a waiting producer.

// File: rtl/hs_relay_pkg.sv
package hs_relay_pkg;

    // Phase of the consumer-side (active) channel.
    typedef enum logic [1:0] {
        OUT_IDLE    = 2'd0,
        OUT_CALLING = 2'd1,
        OUT_RELEASE = 2'd2
    } out_phase_e;

    // Producer-side (passive) registered state.
    typedef struct packed {
        logic ack;
        logic held;
    } in_state_t;

    // An item may be taken when the producer asks, the previous producer
    // handshake is back at zero, the slot is empty and the consumer channel
    // has returned to zero.
    function automatic logic may_take(input logic req,
                                      input logic ack,
                                      input logic held,
                                      input logic cons_ack);
        return req && !ack && !held && !cons_ack;
    endfunction

    // Producer acknowledge is released once the request has gone low.
    function automatic logic may_release(input logic req, input logic ack);
        return ack && !req;
    endfunction

endpackage

// File: rtl/hs_relay_intake.sv
module hs_relay_intake
    import hs_relay_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic prod_req,
    input  logic cons_ack,
    input  logic delivered,
    output logic prod_ack,
    output logic held,
    output logic take
);

    in_state_t st_q;
    in_state_t st_d;

    assign take = may_take(prod_req, st_q.ack, st_q.held, cons_ack);

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.ack  = 1'b1;
            st_d.held = 1'b1;
        end else begin
            if (may_release(prod_req, st_q.ack)) st_d.ack = 1'b0;
            if (delivered)                        st_d.held = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign prod_ack = st_q.ack;
    assign held     = st_q.held;

    p_ack_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(prod_ack) |-> $past(prod_req));

    p_ack_holds_r3: assert property (@(posedge clk) disable iff (rst)
        (prod_ack && prod_req) |=> prod_ack);

    p_ack_returns_r6: assert property (@(posedge clk) disable iff (rst)
        (prod_ack && !prod_req) |=> !prod_ack);

    p_full_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        (held && !delivered && !prod_ack) |=> !prod_ack);

endmodule

// File: rtl/hs_relay_offer.sv
module hs_relay_offer
    import hs_relay_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic held,
    input  logic cons_ack,
    output logic cons_req,
    output logic delivered
);

    out_phase_e ph_q;
    out_phase_e ph_d;

    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            OUT_IDLE:    if (held && !cons_ack) ph_d = OUT_CALLING;
            OUT_CALLING: if (cons_ack)          ph_d = OUT_RELEASE;
            OUT_RELEASE: if (!cons_ack)         ph_d = OUT_IDLE;
            default:                            ph_d = OUT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ph_q <= OUT_IDLE;
        else     ph_q <= ph_d;
    end

    assign cons_req  = (ph_q == OUT_CALLING);
    assign delivered = cons_req && cons_ack;

    p_req_holds_high_r4: assert property (@(posedge clk) disable iff (rst)
        (cons_req && !cons_ack) |=> cons_req);

    p_req_holds_low_r5: assert property (@(posedge clk) disable iff (rst)
        (!cons_req && cons_ack) |=> !cons_req);

    p_req_returns_r6: assert property (@(posedge clk) disable iff (rst)
        (cons_req && cons_ack) |=> !cons_req);

endmodule

// File: rtl/hs_relay_store.sv
module hs_relay_store #(
    parameter int DATA_W   = 8,
    parameter bit HAS_DATA = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              cons_req,
    input  logic [DATA_W-1:0] prod_data,
    output logic [DATA_W-1:0] cons_data
);

    generate
        if (HAS_DATA) begin : g_reg
            logic [DATA_W-1:0] slot_q;

            always_ff @(posedge clk) begin
                if (rst)       slot_q <= '0;
                else if (take) slot_q <= prod_data;
            end

            assign cons_data = cons_req ? slot_q : '0;

            p_data_stable_r11: assert property (@(posedge clk) disable iff (rst)
                (cons_req && $past(cons_req)) |-> $stable(cons_data));

            p_data_zero_idle_r11: assert property (@(posedge clk) disable iff (rst)
                !cons_req |-> (cons_data == '0));
        end else begin : g_none
            logic unused_in;
            assign unused_in = ^{clk, rst, take, cons_req, prod_data};
            assign cons_data = '0;
        end
    endgenerate

endmodule

// File: rtl/hs_relay_ctrl.sv
module hs_relay_ctrl #(
    parameter int DATA_W     = 8,
    parameter bit HAS_DATA   = 1'b1,
    parameter int RESP_LIMIT = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prod_req,
    input  logic [DATA_W-1:0] prod_data,
    output logic              prod_ack,
    output logic              cons_req,
    input  logic              cons_ack,
    output logic [DATA_W-1:0] cons_data
);

    localparam int WAIT_W = $clog2(RESP_LIMIT + 1) + 1;

    logic held;
    logic take;
    logic delivered;

    hs_relay_intake u_intake (
        .clk       (clk),
        .rst       (rst),
        .prod_req  (prod_req),
        .cons_ack  (cons_ack),
        .delivered (delivered),
        .prod_ack  (prod_ack),
        .held      (held),
        .take      (take)
    );

    hs_relay_offer u_offer (
        .clk       (clk),
        .rst       (rst),
        .held      (held),
        .cons_ack  (cons_ack),
        .cons_req  (cons_req),
        .delivered (delivered)
    );

    hs_relay_store #(
        .DATA_W   (DATA_W),
        .HAS_DATA (HAS_DATA)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .cons_req  (cons_req),
        .prod_data (prod_data),
        .cons_data (cons_data)
    );

    // Cycles an accepted item has waited without an offer (checker state).
    logic [WAIT_W-1:0] wait_q;
    always_ff @(posedge clk) begin
        if (rst || !held || cons_req) wait_q <= '0;
        else if (wait_q != {WAIT_W{1'b1}}) wait_q <= wait_q + 1'b1;
    end

    p_offer_in_window_r7: assert property (@(posedge clk) disable iff (rst)
        wait_q < WAIT_W'(RESP_LIMIT));

    p_offer_next_cycle_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(prod_ack) |=> cons_req);

    p_offer_needs_item_r8: assert property (@(posedge clk) disable iff (rst)
        cons_req |-> held);

    p_take_needs_quiet_cons_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(prod_ack) |-> !$past(cons_ack));

    p_reset_clears_r1: assert property (@(posedge clk)
        $past(rst) |-> (!prod_ack && !cons_req && !held));

endmodule

// File: tb/hs_relay_ctrl_test.sv
module hs_relay_ctrl_test;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          prod_req = 1'b0;
    logic [DW-1:0] prod_data = '0;
    logic          prod_ack;
    logic          cons_req;
    logic          cons_ack = 1'b0;
    logic [DW-1:0] cons_data;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    hs_relay_ctrl #(.DATA_W(DW), .HAS_DATA(1'b1), .RESP_LIMIT(5)) uut (
        .clk       (clk),
        .rst       (rst),
        .prod_req  (prod_req),
        .prod_data (prod_data),
        .prod_ack  (prod_ack),
        .cons_req  (cons_req),
        .cons_ack  (cons_ack),
        .cons_data (cons_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    // Runs one configuration of producer / consumer delays, sending n items.
    task automatic run_cfg(input int pd, input int cd, input int cr,
                           input int n, input int seed);
        int sent = 0, taken = 0, got = 0, done_ok = 0;
        int pst = 0, pcnt = 0, ccnt = 0, rcnt = 0;
        int t = 0, take_t = -10;
        logic          p_ack = prod_ack, p_req = cons_req;
        logic [DW-1:0] val_taken = '0;
        while (!done_ok && t < 4000) begin
            @(negedge clk);
            t++;
            // ---- checks on outputs produced by the edge just passed ----
            if (prod_ack && !p_ack) begin
                check(prod_req == 1'b1, "R2", prod_req, 1);
                check(cons_ack == 1'b0, "R10", cons_ack, 0);
                check(taken == got, "R9", taken - got, 0);
                val_taken = prod_data;
                taken++;
                take_t = t;
            end
            if (p_ack && prod_req)  check(prod_ack == 1'b1, "R3", prod_ack, 1);
            if (p_ack && !prod_req) check(prod_ack == 1'b0, "R6", prod_ack, 0);
            if (t == take_t + 1) begin
                check(cons_req == 1'b1, "R7", cons_req, 1);
                check(cons_data == val_taken, "R11", cons_data, val_taken);
            end
            if (cons_req && !p_req) check(taken == got + 1, "R8", taken, got + 1);
            if (p_req && !cons_ack) check(cons_req == 1'b1, "R4", cons_req, 1);
            if (!p_req && cons_ack) check(cons_req == 1'b0, "R5", cons_req, 0);
            if (p_req && cons_ack) begin
                check(cons_req == 1'b0, "R6", cons_req, 0);
                got++;
            end
            if (cons_req) check(cons_data == val_taken, "R11", cons_data, val_taken);
            else if (cons_data != '0) check(1'b0, "R11", cons_data, 0);
            p_ack = prod_ack;
            p_req = cons_req;
            // ---- producer environment ----
            case (pst)
                0: if (sent < n && !prod_ack) begin
                       prod_req  = 1'b1;
                       prod_data = DW'(seed * 7 + sent * 29 + 5);
                       sent++;
                       pst = 1;
                   end
                1: if (prod_ack) begin
                       if (pcnt >= pd) begin prod_req = 1'b0; pcnt = 0; pst = 0; end
                       else pcnt++;
                   end
                default: pst = 0;
            endcase
            // ---- consumer environment ----
            if (cons_req && !cons_ack) begin
                if (ccnt >= cd) begin cons_ack = 1'b1; ccnt = 0; end
                else ccnt++;
            end else if (!cons_req && cons_ack) begin
                if (rcnt >= cr) begin cons_ack = 1'b0; rcnt = 0; end
                else rcnt++;
            end
            done_ok = (got == n) && (pst == 0) && !prod_req && !prod_ack
                      && !cons_req && !cons_ack;
        end
        check(got == n, "R11", got, n);
    endtask

    initial begin
        // R1: reset state, with a request pending during reset
        prod_req = 1'b1;
        prod_data = 8'hA5;
        repeat (3) @(negedge clk);
        check(prod_ack == 1'b0, "R1", prod_ack, 0);
        check(cons_req == 1'b0, "R1", cons_req, 0);
        check(cons_data == '0, "R1", cons_data, 0);
        prod_req = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check(prod_ack == 1'b0 && cons_req == 1'b0, "R1", prod_ack, 0);
        // R1: empty after reset, so the first request is taken at once
        prod_req = 1'b1;
        @(negedge clk);
        check(prod_ack == 1'b1, "R1", prod_ack, 1);
        @(negedge clk);
        check(cons_req == 1'b1 && cons_data == 8'hA5, "R11", cons_data, 8'hA5);
        prod_req = 1'b0;
        cons_ack = 1'b1;
        @(negedge clk);
        cons_ack = 1'b0;
        @(negedge clk);

        // Sweep of producer hold, consumer response and consumer release delays
        for (int pd = 0; pd < 3; pd++)
            for (int cd = 0; cd < 4; cd++)
                for (int cr = 0; cr < 3; cr++)
                    run_cfg(pd, cd, cr, 3, pd * 16 + cd * 4 + cr);

        // R9: very slow consumer stalls a waiting producer
        run_cfg(0, 9, 0, 3, 77);
        // R10: consumer slow to release its acknowledge
        run_cfg(0, 0, 8, 3, 91);

        summary();
        $finish;
    end

endmodule